// File: doc/BRIEF.md
# Register-Mapped SPI Master

This block is a SPI master that software drives through a small 32-bit register port. Software sets the word length, the SCLK divider and the slave-select choice, places a word in a four-entry transmit queue and sets a start bit. The block then shifts the word out on MOSI, MSB first in SPI mode 0, samples MISO on each rising SCLK edge and queues the received word for software to read back.

Chip select can be left to the block, which asserts the chosen line only while a word is moving. Software can also own it, holding one select line low across several words. Events are latched in sticky status flags that software clears by writing ones: word done, queue overflow, queue underrun and a summary error bit. Fill levels and full and empty flags of both queues can be read at any time.

Top module: `spim_regbus`

## Requirements
- R1: After reset the status word reads 0x00A00000 (both queues empty, bits 23 and 21), the command word and divider read 0, SCLK is low and all select lines are high.
- R2: A command write with bit 31 (enable), bit 28 (master) and bit 30 (GO) set sends the low N bits of the next transmit word, where N is bits 4:0 plus one. The most significant used bit goes first. MOSI changes while SCLK is low, and every bit is valid at the rising SCLK edge.
- R3: When command2 bit 31 (receive enable) is set, the N bits sampled from MISO are pushed right-justified, with zeros above, into the receive queue. Software reads that queue at offset 0x180. The transmit queue is written at offset 0x100.
- R4: GO starts a word only when enable and master are both set. Otherwise it has no effect. GO reads back 0 once the word has started. Status bit 31 (busy) is high while the word shifts. Status bit 30 (done) is set when the word completes and stays set.
- R5: Writing 1 to a sticky status bit (30, 25, 24, 19, 18) clears it. Writing 0 leaves it unchanged.
- R6: If GO starts a word while transmit is enabled (command2 bit 30) and the transmit queue is empty, status bit 24 (transmit underrun) is set and zeros are sent.
- R7: The transmit queue holds 4 words. Status bits 21 and 20 are its empty and full flags, and status2 bits 5:0 give its fill count. A write to a full queue is dropped and sets status bit 19.
- R8: Reading the empty receive queue returns 0 and sets status bit 18. A word received while the receive queue holds 4 words is dropped and sets status bit 25. Status bits 23 and 22 are the receive empty and full flags, and status2 bits 21:16 give its fill count.
- R9: With command bit 11 (software select) set, command bit 12 drives low the select line chosen by command2 bits 19:18 when it is 1, and releases it when it is 0. No more than one select line is ever low.
- R10: Status bit 29 reads 1 whenever any of the four overflow or underrun flags is set.
- R11: SCLK stays low whenever no word is shifting. Each SCLK half period lasts D+1 clock cycles, where D is the divider register at offset 0x20.
- R12: With transmit disabled, a word sends zeros, leaves the transmit queue untouched and does not flag an underrun.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_i | input | 1 | Register access strobe, one cycle per access |
| we_i | input | 1 | 1 for write, 0 for read |
| addr_i | input | 9 | Byte address of the register |
| wdata_i | input | 32 | Write data |
| rdata_o | output | 32 | Read data, valid in the cycle of the read strobe |
| sclk_o | output | 1 | SPI serial clock |
| mosi_o | output | 1 | Serial data to the slave |
| miso_i | input | 1 | Serial data from the slave |
| ss_no | output | 4 | Active-low slave selects |

## Verification
The bench pairs the master with a bench-side slave that shifts a different word back, so each transfer checks both directions at once. The words are 8 and 32 bits long with unlike MOSI and MISO patterns, which shows whether bits are reversed or misaligned. A 13-bit word has ones in its unused upper bits, which shows whether only the low bits are sent. A 1-bit word exposes off-by-one errors in the length field. Queue tests fill the transmit queue past its depth and then drain it word by word, which separates the word order and the flags of each queue boundary. The tests that start a word with an empty queue and with transmit disabled show whether the underrun flag depends on the transmit enable bit.

// File: rtl/spim_pkg.sv
package spim_pkg;
  localparam int unsigned REG_AW = 9;
  localparam int unsigned LEN_W  = 5;

  localparam logic [REG_AW-1:0] OFF_CMD   = 9'h000;
  localparam logic [REG_AW-1:0] OFF_CMD2  = 9'h004;
  localparam logic [REG_AW-1:0] OFF_STAT  = 9'h008;
  localparam logic [REG_AW-1:0] OFF_STAT2 = 9'h01C;
  localparam logic [REG_AW-1:0] OFF_DIV   = 9'h020;
  localparam logic [REG_AW-1:0] OFF_TXQ   = 9'h100;
  localparam logic [REG_AW-1:0] OFF_RXQ   = 9'h180;

  // command
  localparam int unsigned C_EN     = 31;
  localparam int unsigned C_GO     = 30;
  localparam int unsigned C_MASTER = 28;
  localparam int unsigned C_CSVAL  = 12;
  localparam int unsigned C_CSSW   = 11;
  // command2
  localparam int unsigned C2_RXEN  = 31;
  localparam int unsigned C2_TXEN  = 30;
  localparam int unsigned C2_SEL   = 18;
  // status
  localparam int unsigned S_BSY    = 31;
  localparam int unsigned S_RDY    = 30;
  localparam int unsigned S_ERR    = 29;
  localparam int unsigned S_RXOVF  = 25;
  localparam int unsigned S_TXUNR  = 24;
  localparam int unsigned S_RXEMP  = 23;
  localparam int unsigned S_RXFUL  = 22;
  localparam int unsigned S_TXEMP  = 21;
  localparam int unsigned S_TXFUL  = 20;
  localparam int unsigned S_TXOVF  = 19;
  localparam int unsigned S_RXUNR  = 18;
  // status2
  localparam int unsigned S2_TXCNT = 0;
  localparam int unsigned S2_RXCNT = 16;
  localparam int unsigned S2_CNT_W = 6;
endpackage

// File: rtl/spim_fifo.sv
module spim_fifo #(
  parameter int unsigned W     = 32,
  parameter int unsigned DEPTH = 4,
  localparam int unsigned CNT_W = $clog2(DEPTH + 1),
  localparam int unsigned PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [W-1:0]     data_i,
  input  logic             pop_i,
  output logic [W-1:0]     data_o,
  output logic             empty_o,
  output logic             full_o,
  output logic [CNT_W-1:0] count_o
);
  logic [W-1:0]     mem_q [DEPTH];
  logic [PTR_W-1:0] wr_q, rd_q;
  logic [CNT_W-1:0] cnt_q;
  logic             do_push, do_pop;

  assign empty_o = (cnt_q == '0);
  assign full_o  = (cnt_q == CNT_W'(DEPTH));
  assign count_o = cnt_q;
  assign data_o  = mem_q[rd_q];
  assign do_push = push_i && !full_o;
  assign do_pop  = pop_i && !empty_o;

  function automatic logic [PTR_W-1:0] nxt(input logic [PTR_W-1:0] p);
    return (p == PTR_W'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk_i) begin
    if (do_push) mem_q[wr_q] <= data_i;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      case ({do_push, do_pop})
        2'b10:   cnt_q <= cnt_q + 1'b1;
        2'b01:   cnt_q <= cnt_q - 1'b1;
        default: cnt_q <= cnt_q;
      endcase
    end
  end
endmodule

// File: rtl/spim_shifter.sv
module spim_shifter #(
  parameter int unsigned DW    = 32,
  parameter int unsigned LEN_W = 5,
  parameter int unsigned DIV_W = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             start_i,
  input  logic [DW-1:0]    word_i,
  input  logic [LEN_W-1:0] len_i,
  input  logic [DIV_W-1:0] div_i,
  output logic             busy_o,
  output logic             done_o,
  output logic [DW-1:0]    rx_o,
  output logic             sclk_o,
  output logic             mosi_o,
  input  logic             miso_i
);
  logic             busy_q, done_q, sclk_q;
  logic [DW-1:0]    tx_q, rx_q;
  logic [LEN_W-1:0] bit_q, len_q;
  logic [DIV_W-1:0] div_q, cnt_q;

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign rx_o   = rx_q;
  assign sclk_o = sclk_q;
  assign mosi_o = busy_q & tx_q[DW-1];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      done_q <= 1'b0;
      sclk_q <= 1'b0;
      tx_q   <= '0;
      rx_q   <= '0;
      bit_q  <= '0;
      len_q  <= '0;
      div_q  <= '0;
      cnt_q  <= '0;
    end else begin
      done_q <= 1'b0;
      if (start_i && !busy_q) begin
        busy_q <= 1'b1;
        sclk_q <= 1'b0;
        // left-align the used bits so the top bit leaves first
        tx_q   <= word_i << (LEN_W'(DW - 1) - len_i);
        rx_q   <= '0;
        bit_q  <= '0;
        len_q  <= len_i;
        div_q  <= div_i;
        cnt_q  <= '0;
      end else if (busy_q) begin
        if (cnt_q == div_q) begin
          cnt_q  <= '0;
          sclk_q <= ~sclk_q;
          if (!sclk_q) begin
            rx_q <= {rx_q[DW-2:0], miso_i};
          end else if (bit_q == len_q) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            tx_q  <= tx_q << 1;
            bit_q <= bit_q + 1'b1;
          end
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/spim_regbus.sv
module spim_regbus
  import spim_pkg::*;
#(
  parameter int unsigned FIFO_DEPTH = 4,
  parameter int unsigned DIV_W      = 8,
  parameter int unsigned NSS        = 4,
  localparam int unsigned DW    = 32,
  localparam int unsigned CNT_W = $clog2(FIFO_DEPTH + 1),
  localparam int unsigned SEL_W = (NSS > 1) ? $clog2(NSS) : 1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_i,
  input  logic              we_i,
  input  logic [REG_AW-1:0] addr_i,
  input  logic [DW-1:0]     wdata_i,
  output logic [DW-1:0]     rdata_o,
  output logic              sclk_o,
  output logic              mosi_o,
  input  logic              miso_i,
  output logic [NSS-1:0]    ss_no
);
  logic             cmd_en, cmd_master, cmd_sw, cmd_csval, go_q;
  logic [LEN_W-1:0] cmd_len;
  logic             c2_rxen, c2_txen;
  logic [SEL_W-1:0] c2_sel;
  logic [DIV_W-1:0] div_q;
  logic             rdy_q, rxf_ovf_q, txf_unr_q, txf_ovf_q, rxf_unr_q;

  logic             wr, rd, tx_wr, rx_rd;
  logic             start, busy, done;
  logic             tx_pop, tx_empty, tx_full, rx_push, rx_empty, rx_full;
  logic [DW-1:0]    tx_head, rx_head, shift_word, rx_word;
  logic [CNT_W-1:0] tx_cnt, rx_cnt;
  logic [DW-1:0]    clr;
  logic             cs_act, err;
  logic [DW-1:0]    stat_w, stat2_w, cmd_w, cmd2_w;

  assign wr    = req_i && we_i;
  assign rd    = req_i && !we_i;
  assign tx_wr = wr && (addr_i == OFF_TXQ);
  assign rx_rd = rd && (addr_i == OFF_RXQ);
  assign clr   = (wr && addr_i == OFF_STAT) ? wdata_i : '0;

  assign start      = go_q && !busy;
  assign tx_pop     = start && c2_txen && !tx_empty;
  assign shift_word = tx_pop ? tx_head : '0;
  assign rx_push    = done && c2_rxen;

  spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_txq (
    .clk_i, .rst_ni,
    .push_i(tx_wr), .data_i(wdata_i), .pop_i(tx_pop), .data_o(tx_head),
    .empty_o(tx_empty), .full_o(tx_full), .count_o(tx_cnt)
  );

  spim_fifo #(.W(DW), .DEPTH(FIFO_DEPTH)) u_rxq (
    .clk_i, .rst_ni,
    .push_i(rx_push), .data_i(rx_word), .pop_i(rx_rd), .data_o(rx_head),
    .empty_o(rx_empty), .full_o(rx_full), .count_o(rx_cnt)
  );

  spim_shifter #(.DW(DW), .LEN_W(LEN_W), .DIV_W(DIV_W)) u_shift (
    .clk_i, .rst_ni,
    .start_i(start), .word_i(shift_word), .len_i(cmd_len), .div_i(div_q),
    .busy_o(busy), .done_o(done), .rx_o(rx_word),
    .sclk_o, .mosi_o, .miso_i
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cmd_en <= 1'b0; cmd_master <= 1'b0; cmd_sw <= 1'b0; cmd_csval <= 1'b0;
      go_q <= 1'b0; cmd_len <= '0;
      c2_rxen <= 1'b0; c2_txen <= 1'b0; c2_sel <= '0;
      div_q <= '0;
    end else begin
      if (wr && addr_i == OFF_CMD) begin
        cmd_en     <= wdata_i[C_EN];
        cmd_master <= wdata_i[C_MASTER];
        cmd_sw     <= wdata_i[C_CSSW];
        cmd_csval  <= wdata_i[C_CSVAL];
        cmd_len    <= wdata_i[LEN_W-1:0];
        go_q       <= wdata_i[C_GO] & wdata_i[C_EN] & wdata_i[C_MASTER];
      end else if (start) begin
        go_q <= 1'b0;
      end
      if (wr && addr_i == OFF_CMD2) begin
        c2_rxen <= wdata_i[C2_RXEN];
        c2_txen <= wdata_i[C2_TXEN];
        c2_sel  <= wdata_i[C2_SEL +: SEL_W];
      end
      if (wr && addr_i == OFF_DIV) div_q <= wdata_i[DIV_W-1:0];
    end
  end

  // sticky flags: a new event wins over a same-cycle clear
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdy_q <= 1'b0; rxf_ovf_q <= 1'b0; txf_unr_q <= 1'b0;
      txf_ovf_q <= 1'b0; rxf_unr_q <= 1'b0;
    end else begin
      rdy_q     <= done | (rdy_q & ~clr[S_RDY]);
      rxf_ovf_q <= (rx_push && rx_full) | (rxf_ovf_q & ~clr[S_RXOVF]);
      txf_unr_q <= (start && c2_txen && tx_empty) | (txf_unr_q & ~clr[S_TXUNR]);
      txf_ovf_q <= (tx_wr && tx_full) | (txf_ovf_q & ~clr[S_TXOVF]);
      rxf_unr_q <= (rx_rd && rx_empty) | (rxf_unr_q & ~clr[S_RXUNR]);
    end
  end

  assign err = rxf_ovf_q | txf_unr_q | txf_ovf_q | rxf_unr_q;

  always_comb begin
    stat_w          = '0;
    stat_w[S_BSY]   = busy;
    stat_w[S_RDY]   = rdy_q;
    stat_w[S_ERR]   = err;
    stat_w[S_RXOVF] = rxf_ovf_q;
    stat_w[S_TXUNR] = txf_unr_q;
    stat_w[S_RXEMP] = rx_empty;
    stat_w[S_RXFUL] = rx_full;
    stat_w[S_TXEMP] = tx_empty;
    stat_w[S_TXFUL] = tx_full;
    stat_w[S_TXOVF] = txf_ovf_q;
    stat_w[S_RXUNR] = rxf_unr_q;

    stat2_w = '0;
    stat2_w[S2_TXCNT +: S2_CNT_W] = S2_CNT_W'(tx_cnt);
    stat2_w[S2_RXCNT +: S2_CNT_W] = S2_CNT_W'(rx_cnt);

    cmd_w             = '0;
    cmd_w[C_EN]       = cmd_en;
    cmd_w[C_GO]       = go_q;
    cmd_w[C_MASTER]   = cmd_master;
    cmd_w[C_CSVAL]    = cmd_csval;
    cmd_w[C_CSSW]     = cmd_sw;
    cmd_w[LEN_W-1:0]  = cmd_len;

    cmd2_w                  = '0;
    cmd2_w[C2_RXEN]         = c2_rxen;
    cmd2_w[C2_TXEN]         = c2_txen;
    cmd2_w[C2_SEL +: SEL_W] = c2_sel;
  end

  always_comb begin
    rdata_o = '0;
    if (rd) begin
      case (addr_i)
        OFF_CMD:   rdata_o = cmd_w;
        OFF_CMD2:  rdata_o = cmd2_w;
        OFF_STAT:  rdata_o = stat_w;
        OFF_STAT2: rdata_o = stat2_w;
        OFF_DIV:   rdata_o = DW'(div_q);
        OFF_RXQ:   rdata_o = rx_empty ? '0 : rx_head;
        default:   rdata_o = '0;
      endcase
    end
  end

  assign cs_act = cmd_sw ? cmd_csval : busy;

  for (genvar g = 0; g < NSS; g++) begin : g_ss
    assign ss_no[g] = ~(cs_act && (c2_sel == SEL_W'(g)));
  end
endmodule

// File: rtl/spim_checker.sv
module spim_checker #(
  parameter int unsigned NSS   = 4,
  parameter int unsigned CNT_W = 3,
  parameter int unsigned DEPTH = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             busy,
  input logic             done,
  input logic             start,
  input logic             sclk_o,
  input logic [NSS-1:0]   ss_no,
  input logic             cmd_en,
  input logic             cmd_master,
  input logic             c2_txen,
  input logic             tx_empty,
  input logic             tx_full,
  input logic             tx_wr,
  input logic             rdy_q,
  input logic             txf_unr_q,
  input logic             txf_ovf_q,
  input logic [CNT_W-1:0] tx_cnt,
  input logic [CNT_W-1:0] rx_cnt
);
  p_one_select_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~ss_no));

  p_sclk_idle_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy |-> !sclk_o);

  p_start_enabled_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |-> (cmd_en && cmd_master));

  p_busy_after_go_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    start |=> busy);

  p_rdy_set_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> rdy_q);

  p_underrun_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (start && c2_txen && tx_empty) |=> txf_unr_q);

  p_tx_overflow_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_wr && tx_full) |=> txf_ovf_q);

  p_fifo_bound_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (tx_cnt <= CNT_W'(DEPTH)) && (rx_cnt <= CNT_W'(DEPTH)));
endmodule

bind spim_regbus spim_checker #(
  .NSS(NSS), .CNT_W(CNT_W), .DEPTH(FIFO_DEPTH)
) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .busy(busy), .done(done), .start(start),
  .sclk_o(sclk_o), .ss_no(ss_no), .cmd_en(cmd_en), .cmd_master(cmd_master),
  .c2_txen(c2_txen), .tx_empty(tx_empty), .tx_full(tx_full), .tx_wr(tx_wr),
  .rdy_q(rdy_q), .txf_unr_q(txf_unr_q), .txf_ovf_q(txf_ovf_q),
  .tx_cnt(tx_cnt), .rx_cnt(rx_cnt)
);

// File: tb/spim_regbus_bench.sv
`timescale 1ns/1ps
module spim_regbus_bench;
  localparam logic [8:0] A_CMD = 9'h000, A_CMD2 = 9'h004, A_STAT = 9'h008,
                         A_STAT2 = 9'h01C, A_DIV = 9'h020, A_TXQ = 9'h100, A_RXQ = 9'h180;
  localparam logic [31:0] M_EN = 32'h8000_0000, M_GO = 32'h4000_0000, M_MS = 32'h1000_0000;
  localparam logic [31:0] M_CSVAL = 32'h0000_1000, M_CSSW = 32'h0000_0800;
  localparam logic [31:0] M_RXEN = 32'h8000_0000, M_TXEN = 32'h4000_0000;
  localparam logic [31:0] B_BSY = 32'h8000_0000, B_RDY = 32'h4000_0000, B_ERR = 32'h2000_0000;
  localparam logic [31:0] B_RXOVF = 32'h0200_0000, B_TXUNR = 32'h0100_0000;
  localparam logic [31:0] B_RXEMP = 32'h0080_0000, B_RXFUL = 32'h0040_0000;
  localparam logic [31:0] B_TXEMP = 32'h0020_0000, B_TXFUL = 32'h0010_0000;
  localparam logic [31:0] B_TXOVF = 32'h0008_0000, B_RXUNR = 32'h0004_0000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic req = 1'b0, we = 1'b0;
  logic [8:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic sclk, mosi, miso;
  logic [3:0] ss_n;

  int n_checks = 0, n_err = 0;
  bit finished = 0;

  logic [31:0] slv_tx = '0, slv_rx = '0, slv_val = '0;
  logic slv_ld = 1'b0;
  logic meas_clr = 1'b1;
  int hi_run = 0, hi_max = 0;

  always #2 clk = ~clk;

  spim_regbus u_spim_regbus (
    .clk_i(clk), .rst_ni(rst_n), .req_i(req), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .sclk_o(sclk), .mosi_o(mosi),
    .miso_i(miso), .ss_no(ss_n)
  );

  // slave model, mode 0
  assign miso = slv_tx[31];
  always @(negedge sclk or posedge slv_ld) begin
    if (slv_ld) slv_tx <= slv_val;
    else        slv_tx <= slv_tx << 1;
  end
  always @(posedge sclk) slv_rx <= {slv_rx[30:0], mosi};

  always @(posedge clk) begin
    if (meas_clr) begin
      hi_run <= 0; hi_max <= 0;
    end else if (sclk) begin
      hi_run <= hi_run + 1;
      if (hi_run + 1 > hi_max) hi_max <= hi_run + 1;
    end else begin
      hi_run <= 0;
    end
  end

  task automatic chk(input string req_s, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual %h expected %h", req_s, act, exp);
    end
  endtask

  task automatic reg_wr(input logic [8:0] a, input logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    req = 1'b0; we = 1'b0;
  endtask

  task automatic reg_rd(input logic [8:0] a, output logic [31:0] d);
    @(negedge clk);
    req = 1'b1; we = 1'b0; addr = a;
    #1 d = rdata;
    @(negedge clk);
    req = 1'b0;
  endtask

  task automatic wait_rdy();
    logic [31:0] s;
    for (int i = 0; i < 4000; i++) begin
      reg_rd(A_STAT, s);
      if (s[30]) break;
    end
  endtask

  function automatic logic [31:0] mask(input int nb);
    return (nb >= 32) ? 32'hFFFF_FFFF : ((32'h1 << nb) - 1);
  endfunction

  task automatic xfer(input int nb, input logic [31:0] txw, input logic [31:0] slvw,
                      input logic [7:0] dv, input bit load, input bit rdchk, input string rq);
    logic [31:0] v;
    reg_wr(A_DIV, {24'h0, dv});
    if (load) reg_wr(A_TXQ, txw);
    @(negedge clk);
    slv_val = slvw << (32 - nb);
    slv_ld = 1'b1; #1 slv_ld = 1'b0;
    reg_wr(A_STAT, 32'hFFFF_FFFF);
    reg_wr(A_CMD, M_EN | M_MS | M_GO | 32'(nb - 1));
    wait_rdy();
    chk({rq, " mosi bits"}, slv_rx & mask(nb), txw & mask(nb));
    if (rdchk) begin
      reg_rd(A_RXQ, v);
      chk("R3 rx word", v, slvw & mask(nb));
    end
  endtask

  task automatic t_reset();
    logic [31:0] v;
    reg_rd(A_STAT, v); chk("R1 status", v, B_RXEMP | B_TXEMP);
    reg_rd(A_CMD, v);  chk("R1 command", v, 32'h0);
    reg_rd(A_DIV, v);  chk("R1 divider", v, 32'h0);
    chk("R1 select lines", {28'h0, ss_n}, 32'hF);
    chk("R1 sclk", {31'h0, sclk}, 32'h0);
  endtask

  task automatic t_basic();
    logic [31:0] v;
    reg_wr(A_CMD2, M_RXEN | M_TXEN);
    xfer(8, 32'h0000_00A5, 32'h0000_003C, 8'd0, 1, 1, "R2 8-bit");
    reg_rd(A_STAT, v); chk("R4 done sticky, not busy", v & (B_RDY | B_BSY), B_RDY);
    reg_rd(A_CMD, v);  chk("R4 go self-clears", v & M_GO, 32'h0);
    xfer(32, 32'hDEAD_BEEF, 32'h1234_5678, 8'd2, 1, 1, "R2 32-bit");
    xfer(13, 32'hFFFF_A5A5, 32'h0000_1B6D, 8'd1, 1, 1, "R2 13-bit upper ignored");
    xfer(1, 32'h0000_0001, 32'h0000_0001, 8'd0, 1, 1, "R2 1-bit");
  endtask

  task automatic t_w1c();
    logic [31:0] v;
    reg_wr(A_STAT, 32'h0);
    reg_rd(A_STAT, v); chk("R5 zero write keeps done", v & B_RDY, B_RDY);
    reg_wr(A_STAT, B_RDY);
    reg_rd(A_STAT, v); chk("R5 one write clears done", v & B_RDY, 32'h0);
  endtask

  task automatic t_disabled();
    logic [31:0] v;
    reg_wr(A_STAT, 32'hFFFF_FFFF);
    reg_wr(A_CMD, M_MS | M_GO | 32'd7);
    repeat (40) @(negedge clk);
    reg_rd(A_STAT, v); chk("R4 go without enable ignored", v & (B_RDY | B_BSY), 32'h0);
  endtask

  task automatic t_divider();
    meas_clr = 1'b0;
    xfer(8, 32'h0000_0081, 32'h0000_0018, 8'd3, 1, 1, "R11 div 3");
    chk("R11 sclk high time", 32'(hi_max), 32'd4);
    meas_clr = 1'b1;
  endtask

  task automatic t_select();
    reg_wr(A_CMD2, M_RXEN | M_TXEN | (32'd2 << 18));
    reg_wr(A_CMD, M_EN | M_MS | M_CSSW | M_CSVAL | 32'd7);
    @(negedge clk);
    chk("R9 line 2 low", {28'h0, ss_n}, 32'hB);
    reg_wr(A_CMD, M_EN | M_MS | M_CSSW | 32'd7);
    @(negedge clk);
    chk("R9 released", {28'h0, ss_n}, 32'hF);
    reg_wr(A_CMD2, M_RXEN | M_TXEN);
  endtask

  task automatic t_underrun();
    logic [31:0] v;
    xfer(8, 32'h0, 32'h0000_0042, 8'd0, 0, 1, "R6 zeros sent");
    reg_rd(A_STAT, v); chk("R6 underrun flag", v & B_TXUNR, B_TXUNR);
    chk("R10 error bit", v & B_ERR, B_ERR);
  endtask

  task automatic t_queues();
    logic [31:0] v;
    reg_wr(A_STAT, 32'hFFFF_FFFF);
    for (int i = 0; i < 5; i++) reg_wr(A_TXQ, 32'h10 + 32'(i));
    reg_rd(A_STAT2, v); chk("R7 tx count", v & 32'h3F, 32'd4);
    reg_rd(A_STAT, v);
    chk("R7 full and overflow", v & (B_TXFUL | B_TXOVF | B_TXEMP), B_TXFUL | B_TXOVF);
    for (int i = 0; i < 4; i++)
      xfer(8, 32'h10 + 32'(i), 32'h60 + 32'(i), 8'd0, 0, 0, "R7 queue order");
    reg_rd(A_STAT2, v); chk("R8 rx count", v & 32'h003F_0000, 32'h0004_0000);
    xfer(8, 32'h0, 32'h77, 8'd0, 0, 0, "R6 empty queue");
    reg_rd(A_STAT, v);
    chk("R8 rx overflow and full", v & (B_RXOVF | B_RXFUL), B_RXOVF | B_RXFUL);
    for (int i = 0; i < 4; i++) begin
      reg_rd(A_RXQ, v); chk("R8 rx kept order", v, 32'h60 + 32'(i));
    end
    reg_wr(A_STAT, 32'hFFFF_FFFF);
    reg_rd(A_RXQ, v);  chk("R8 empty read data", v, 32'h0);
    reg_rd(A_STAT, v); chk("R8 rx underrun", v & (B_RXUNR | B_RXEMP | B_ERR), B_RXUNR | B_RXEMP | B_ERR);
    reg_wr(A_STAT, B_RXUNR);
    reg_rd(A_STAT, v); chk("R10 error clears with flags", v & B_ERR, 32'h0);
  endtask

  task automatic t_txoff();
    logic [31:0] v;
    reg_wr(A_TXQ, 32'h0000_0055);
    reg_wr(A_CMD2, M_RXEN);
    xfer(8, 32'h0, 32'h0000_0011, 8'd0, 0, 1, "R12 zeros with tx off");
    reg_rd(A_STAT, v);  chk("R12 no underrun", v & B_TXUNR, 32'h0);
    reg_rd(A_STAT2, v); chk("R12 tx queue untouched", v & 32'h3F, 32'd1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_basic();
    t_w1c();
    t_disabled();
    t_divider();
    t_select();
    t_underrun();
    t_queues();
    t_txoff();
    repeat (5) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_checks++;
      n_err++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", n_checks, n_err);
      $finish;
    end
  end
endmodule